// File: doc/BRIEF.md
# Timed Write Pulse Generator

This block produces the antenna driver-off request while a reader front end is in its tag-write mode. The command decoder hands it one of two entry strobes: a long entry that also carries a 4-bit width value N, and a short entry that reuses whatever N was stored last. With N equal to zero the block is transparent, so the serial data line gates the drivers directly. With N between 1 and 15 each rising edge on the data line starts one driver-off pulse. The pulse is aligned to the first carrier tick after the edge and lasts exactly N carrier periods.

Write mode ends on a rising edge of the serial clock. Any pulse still running is cut short in that cycle. A separate flag stays high for the whole of write mode, so the receive path can hold its demodulator frozen. The configuration-page driver disable is ORed into the driver-off output at all times.

States: `WS_IDLE` (not in write mode), `WS_PASS` (transparent, N = 0), `WS_ARMED` (timed mode, waiting for a data rising edge), `WS_LATCHED` (edge seen, waiting for the first carrier tick), `WS_PULSE` (drivers off, counting carrier ticks).

Transitions:
- `enter`: any state moves to `WS_PASS` or `WS_ARMED` on an entry strobe, picked by the effective N. This transition has priority over all others.
- `exit`: an active state moves to `WS_IDLE` on a serial clock rise.
- `arm_hit`: `WS_ARMED` moves to `WS_LATCHED` on a data rise.
- `align`: `WS_LATCHED` moves to `WS_PULSE` on a carrier tick.
- `expire`: `WS_PULSE` moves to `WS_ARMED` on the tick that ends the Nth period.

Top module: `tag_write_pulser`

## Requirements
- R1: After reset the block is out of write mode (`wr_active_o` = 0), the stored N is 0, and `drv_off_o` equals `cfg_drv_dis_i`.
- R2: A long entry strobe stores `n_val_i` as N. `wr_active_o` is high in the cycle after any entry strobe and stays high until an exit. When both strobes are high in the same cycle, the long strobe wins.
- R3: With an effective N of 0, the block is in transparent mode. `drv_off_o` follows `din_i` in the same cycle: data high means drivers off, data low means drivers on.
- R4: With an effective N from 1 to 15, a rising `din_i` edge is followed by `drv_off_o` rising 1 to P cycles later, where P is the spacing of the carrier ticks. The output rises in the cycle after the first tick that comes after the edge-sampling cycle. It then stays high for exactly N×P cycles.
- R5: A rising `din_i` edge that arrives while a pulse is pending or running is ignored. It does not stretch the pulse or start a second one.
- R6: A short entry strobe reuses the most recently stored N. After reset, with no long entry yet, it selects transparent mode.
- R7: A rising `sclk_i` edge ends write mode. `wr_active_o` falls and any timed driver-off is released in the next cycle, even in the middle of a pulse. An entry strobe in the same cycle as the rise takes priority over the exit.
- R8: `cfg_drv_dis_i` high forces `drv_off_o` high in every state.
- R9: Once a pulse expires, the block re-arms without leaving write mode. The next rising `din_i` edge produces another full pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| carrier_tick_i | input | 1 | One-cycle strobe once per carrier period |
| din_i | input | 1 | Synchronized serial data line |
| sclk_i | input | 1 | Synchronized serial clock line |
| enter_long_i | input | 1 | Entry strobe that also loads N |
| enter_short_i | input | 1 | Entry strobe that reuses the stored N |
| n_val_i | input | 4 | Width value N sampled with the long strobe |
| cfg_drv_dis_i | input | 1 | Configuration-page driver disable |
| drv_off_o | output | 1 | Driver-off request to the antenna drivers |
| wr_active_o | output | 1 | High while in write mode, used for the demodulator clamp |

## Verification
Entry and exit strobes take effect one cycle after the edge that samples them, so the bench reads `wr_active_o` just after that edge. In transparent mode `drv_off_o` is combinational from `din_i`, so it is compared in the same cycle the data is driven. For a timed pulse the bench counts the high samples taken just after each rising clock edge and compares the total with N×P. It also requires the low samples between the data edge and the pulse to number between 1 and P.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [2:0] {
        WS_IDLE    = 3'd0,
        WS_PASS    = 3'd1,
        WS_ARMED   = 3'd2,
        WS_LATCHED = 3'd3,
        WS_PULSE   = 3'd4
    } wstate_t;
endpackage

// File: rtl/wp_rise_det.sv
// Rising-edge detector for a bundle of already-synchronized lines.
module wp_rise_det #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= sig_i;
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign rise_o[g] = sig_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/wp_width_store.sv
// Holds the most recently programmed pulse width; zero after reset.
module wp_width_store #(
    parameter int NW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [NW-1:0] val_i,
    output logic [NW-1:0] n_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     n_o <= '0;
        else if (load_i) n_o <= val_i;
    end
endmodule

// File: rtl/wp_tick_counter.sv
// Counts carrier ticks down from a loaded width while running.
module wp_tick_counter #(
    parameter int NW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [NW-1:0] load_val_i,
    input  logic          run_i,
    input  logic          tick_i,
    output logic [NW-1:0] cnt_o,
    output logic          last_o
);
    localparam logic [NW-1:0] ONE = NW'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          cnt_o <= '0;
        else if (load_i)                      cnt_o <= load_val_i;
        else if (run_i && tick_i && cnt_o != '0) cnt_o <= cnt_o - ONE;
    end

    assign last_o = (cnt_o == ONE);
endmodule

// File: rtl/tag_write_pulser.sv
module tag_write_pulser #(
    parameter int NW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          carrier_tick_i,
    input  logic          din_i,
    input  logic          sclk_i,
    input  logic          enter_long_i,
    input  logic          enter_short_i,
    input  logic [NW-1:0] n_val_i,
    input  logic          cfg_drv_dis_i,
    output logic          drv_off_o,
    output logic          wr_active_o
);
    import wp_pkg::*;

    localparam int RISE_W = 2;
    localparam int IDX_DIN  = 0;
    localparam int IDX_SCLK = 1;

    wstate_t       state_q, state_d;
    logic [RISE_W-1:0] rise_w;
    logic          din_rise, sclk_rise, entry_any;
    logic [NW-1:0] n_stored, n_eff, cnt_w;
    logic          cnt_last, cnt_load;

    wp_rise_det #(.W(RISE_W)) u_rise (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  ({sclk_i, din_i}),
        .rise_o (rise_w)
    );
    assign din_rise  = rise_w[IDX_DIN];
    assign sclk_rise = rise_w[IDX_SCLK];
    assign entry_any = enter_long_i | enter_short_i;

    wp_width_store #(.NW(NW)) u_store (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (enter_long_i),
        .val_i  (n_val_i),
        .n_o    (n_stored)
    );
    assign n_eff = enter_long_i ? n_val_i : n_stored;

    assign cnt_load = (state_q == WS_LATCHED) && carrier_tick_i
                      && !sclk_rise && !entry_any;

    wp_tick_counter #(.NW(NW)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load),
        .load_val_i (n_stored),
        .run_i      (state_q == WS_PULSE),
        .tick_i     (carrier_tick_i),
        .cnt_o      (cnt_w),
        .last_o     (cnt_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:    state_d = WS_IDLE;
            WS_PASS:    if (sclk_rise) state_d = WS_IDLE;
            WS_ARMED: begin
                if (sclk_rise)     state_d = WS_IDLE;
                else if (din_rise) state_d = WS_LATCHED;
            end
            WS_LATCHED: begin
                if (sclk_rise)           state_d = WS_IDLE;
                else if (carrier_tick_i) state_d = WS_PULSE;
            end
            WS_PULSE: begin
                if (sclk_rise)                       state_d = WS_IDLE;
                else if (carrier_tick_i && cnt_last) state_d = WS_ARMED;
            end
            default:    state_d = WS_IDLE;
        endcase
        if (entry_any) state_d = (n_eff == '0) ? WS_PASS : WS_ARMED;
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= WS_IDLE;
        else         state_q <= state_d;
    end

    // Outputs
    always_comb begin
        wr_active_o = 1'b1;
        drv_off_o   = cfg_drv_dis_i;
        unique case (state_q)
            WS_IDLE:    wr_active_o = 1'b0;
            WS_PASS:    drv_off_o   = cfg_drv_dis_i | din_i;
            WS_ARMED:   drv_off_o   = cfg_drv_dis_i;
            WS_LATCHED: drv_off_o   = cfg_drv_dis_i;
            WS_PULSE:   drv_off_o   = 1'b1;
            default: begin
                wr_active_o = 1'b0;
                drv_off_o   = cfg_drv_dis_i;
            end
        endcase
    end
endmodule

// File: rtl/tag_write_pulser_chk.sv
module tag_write_pulser_chk #(
    parameter int NW = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            carrier_tick_i,
    input logic            sclk_i,
    input logic            enter_long_i,
    input logic            enter_short_i,
    input logic            cfg_drv_dis_i,
    input logic            drv_off_o,
    input logic            wr_active_o,
    input wp_pkg::wstate_t state_q,
    input logic [NW-1:0]   cnt_w,
    input logic [NW-1:0]   n_stored
);
    import wp_pkg::*;

    logic no_entry;
    assign no_entry = !enter_long_i && !enter_short_i;

    // R1, R8: outside write mode the output carries only the config disable
    p_idle_out_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_active_o |-> (drv_off_o == cfg_drv_dis_i));

    p_cfg_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_drv_dis_i |-> drv_off_o);

    p_entry_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enter_long_i || enter_short_i) |=> wr_active_o);

    p_sclk_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(sclk_i) && no_entry && wr_active_o) |=> !wr_active_o);

    p_pulse_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == WS_PULSE && !carrier_tick_i && !$rose(sclk_i) && no_entry)
        |=> (state_q == WS_PULSE && drv_off_o));

    p_pulse_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == WS_LATCHED && carrier_tick_i && !$rose(sclk_i) && no_entry)
        |=> (state_q == WS_PULSE && cnt_w == $past(n_stored)));

    p_pulse_cnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == WS_PULSE) |-> (cnt_w != '0));
endmodule

bind tag_write_pulser tag_write_pulser_chk #(.NW(NW)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .carrier_tick_i (carrier_tick_i),
    .sclk_i         (sclk_i),
    .enter_long_i   (enter_long_i),
    .enter_short_i  (enter_short_i),
    .cfg_drv_dis_i  (cfg_drv_dis_i),
    .drv_off_o      (drv_off_o),
    .wr_active_o    (wr_active_o),
    .state_q        (state_q),
    .cnt_w          (cnt_w),
    .n_stored       (n_stored)
);

// File: tb/tag_write_pulser_tb_top.sv
module tag_write_pulser_tb_top;
    localparam int P = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       din = 1'b0;
    logic       sclk = 1'b0;
    logic       e_long = 1'b0;
    logic       e_short = 1'b0;
    logic [3:0] n_val = 4'd0;
    logic       cfg = 1'b0;
    logic       drv_off, wr_act;

    int n_tests = 0;
    int n_fail = 0;
    int tcnt = 0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (!rst_n) begin
            tcnt = 0;
            tick = 1'b0;
        end else begin
            tick = (tcnt == P - 1);
            tcnt = (tcnt == P - 1) ? 0 : tcnt + 1;
        end
    end

    tag_write_pulser #(.NW(4)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .carrier_tick_i (tick),
        .din_i          (din),
        .sclk_i         (sclk),
        .enter_long_i   (e_long),
        .enter_short_i  (e_short),
        .n_val_i        (n_val),
        .cfg_drv_dis_i  (cfg),
        .drv_off_o      (drv_off),
        .wr_active_o    (wr_act)
    );

    function automatic int exp_width(input int n);
        return n * P;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic enter(input bit is_long, input logic [3:0] n);
        e_long = is_long; e_short = !is_long; n_val = n;
        cyc();
        e_long = 0; e_short = 0;
        chk(wr_act == 1'b1, "R2 entry active", wr_act, 1);
    endtask

    task automatic leave();
        sclk = 1'b1;
        cyc();
        chk(wr_act == 1'b0, "R7 exit active", wr_act, 0);
        chk(drv_off == cfg, "R7 exit release", drv_off, cfg);
        sclk = 1'b0;
        cyc();
    endtask

    task automatic pulse(input int n, input bit scramble, input string req);
        int width = 0;
        int delay = 0;
        bit started = 0;
        din = 1'b1;
        for (int i = 0; i < 400; i++) begin
            cyc();
            if (drv_off) begin
                width++;
                started = 1;
            end else if (started) begin
                break;
            end else begin
                delay++;
            end
            if (started)
                din = (scramble && width < exp_width(n) - 2) ? 1'($urandom % 2) : 1'b0;
        end
        din = 1'b0;
        chk(width == exp_width(n), {req, " width"}, width, exp_width(n));
        chk(delay >= 1 && delay <= P, {req, " align delay"}, delay, P);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(wr_act == 1'b0, "R1 reset active", wr_act, 0);
        chk(drv_off == 1'b0, "R1 reset drv", drv_off, 0);
        cfg = 1'b1; #1;
        chk(drv_off == 1'b1, "R8 cfg in idle", drv_off, 1);
        cfg = 1'b0;
        rst_n = 1'b1;
        cyc();
        chk(wr_act == 1'b0, "R1 after reset", wr_act, 0);

        // R6: short entry before any long entry is transparent
        enter(1'b0, 4'd9);
        for (int i = 0; i < 6; i++) begin
            din = 1'($urandom % 2); #1;
            chk(drv_off == din, "R6 R3 transparent", drv_off, din);
            cyc();
        end
        din = 1'b0;
        leave();

        // R3 explicit long entry with N = 0
        enter(1'b1, 4'd0);
        din = 1'b1; #1;
        chk(drv_off == 1'b1, "R3 din high", drv_off, 1);
        din = 1'b0; #1;
        chk(drv_off == 1'b0, "R3 din low", drv_off, 0);
        leave();

        // R4, R9 timed pulses with re-arm
        enter(1'b1, 4'd3);
        cyc();
        pulse(3, 1'b0, "R4 n3");
        repeat (2) cyc();
        chk(drv_off == 1'b0 && wr_act, "R9 rearmed idle low", drv_off, 0);
        pulse(3, 1'b0, "R9 second pulse");
        leave();

        // R6 short entry reuses N = 3
        enter(1'b0, 4'd0);
        cyc();
        pulse(3, 1'b0, "R6 reuse");
        leave();

        // R4 boundaries N = 1 and N = 15, R5 with din toggling
        enter(1'b1, 4'd1);
        cyc();
        pulse(1, 1'b0, "R4 n1");
        leave();
        enter(1'b1, 4'd15);
        cyc();
        pulse(15, 1'b1, "R5 n15 scrambled");
        leave();

        // R7 mid-pulse exit
        enter(1'b1, 4'd10);
        cyc();
        din = 1'b1;
        repeat (P + 6) cyc();
        chk(drv_off == 1'b1, "R7 pulse running", drv_off, 1);
        din = 1'b0;
        leave();

        // R7 priority: entry with sclk rise in the same cycle
        sclk = 1'b1; e_long = 1'b1; n_val = 4'd2;
        cyc();
        e_long = 1'b0;
        chk(wr_act == 1'b1, "R7 entry wins", wr_act, 1);
        sclk = 1'b0;
        cyc();
        // R8 during armed
        cfg = 1'b1; #1;
        chk(drv_off == 1'b1, "R8 cfg armed", drv_off, 1);
        cfg = 1'b0;
        // R2 both strobes: long wins, N = 0 -> transparent
        e_long = 1'b1; e_short = 1'b1; n_val = 4'd0;
        cyc();
        e_long = 1'b0; e_short = 1'b0;
        din = 1'b1; #1;
        chk(drv_off == 1'b1, "R2 long wins", drv_off, 1);
        din = 1'b0;
        leave();

        // Random phase
        for (int k = 0; k < 24; k++) begin
            logic [3:0] n = 4'($urandom % 16);
            enter(1'b1, n);
            if (($urandom % 2) == 1) begin
                leave();
                enter(1'b0, 4'd0);
            end
            repeat (1 + ($urandom % 5)) cyc();
            if (n == 0) begin
                for (int i = 0; i < 4; i++) begin
                    din = 1'($urandom % 2); #1;
                    chk(drv_off == din, "R3 random transparent", drv_off, din);
                    cyc();
                end
                din = 1'b0;
            end else begin
                pulse(n, 1'($urandom % 2), "R4 R5 random");
            end
            leave();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule